// File: doc/BRIEF.md
# Backplane Busy Line Monitor

This block watches a vector of busy signals that readout boards drive onto a shared backplane. It gives a register interface three read words for these signals. The first is a live view of the raw lines. The second is a sticky record of every leading edge since the last clear. The third is a long-busy flag. The long-busy flag is raised only when a line stays asserted for roughly sixteen to thirty-two clocks.

Software uses the live word to see the instantaneous state. It uses the edge word to learn whether a board went busy at all. It uses the long-busy word to tell a stuck or overloaded board from ordinary short busy pulses. A write strobe for each sticky word clears all of that word's bits. Decoding the bus is done outside the block.

Internally, the asynchronous lines pass through a two-stage synchroniser. A free-running prescaler provides a qualification tick every `2**PRESCALE_W` clocks. A line earns its long-busy flag on the second tick it sees while it has been continuously high.

Top module: `busy_watch_regs`

## Requirements
- R1: `liveRd` equals `busyIn` combinationally at all times, with no register in the path, including while reset is asserted.
- R2: When a line rises, its bit in `latchRd` becomes 1 after the third rising clock edge that follows the input change. This counts two synchroniser stages and one edge register. The bit then stays 1 until it is cleared.
- R3: A prescaler ticks on every rising edge whose index since reset release is a multiple of 16. The index counts from 1 at the first edge after release. A line's `monRd` bit sets at the second tick for which the synchronised line has been continuously high. The synchronised line at edge k is the input as sampled at edge k-2. The bit never sets for a pulse seen by 16 or fewer edges. It always sets for a pulse seen by 33 or more edges.
- R4: A one-cycle `wrLatch` pulse clears every bit of `latchRd`. A one-cycle `wrMon` pulse clears every bit of `monRd`.
- R5: If a latch-setting edge coincides with a `wrLatch` pulse, that bit remains 1. If a monitor-setting tick coincides with a `wrMon` pulse, that bit remains 1.
- R6: Active-low reset `rstN` clears both sticky words, all qualification state and the prescaler.
- R7: After a `wrLatch` clear, a line that is still high does not set its latch bit again until a new rising edge. After a `wrMon` clear, a line that is still high sets its monitor bit again at the next tick.
- R8: Lines are independent: activity on one line changes no other bit of `latchRd` or `monRd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busyIn | input | 16 | Asynchronous busy lines from the backplane |
| wrLatch | input | 1 | One-cycle write strobe that clears the edge word |
| wrMon | input | 1 | One-cycle write strobe that clears the long-busy word |
| liveRd | output | 16 | Live, unregistered busy lines |
| latchRd | output | 16 | Sticky leading-edge flags |
| monRd | output | 16 | Sticky long-busy flags |

## Verification
The embedded assertions check the following on every cycle:
- A new edge flag only appears on a line that is high after synchronisation.
- A long-busy flag only rises on a tick, after the line has been high for two samples.
- Edge flags never drop without a write.
- A write leaves only the bits that a same-cycle event has just set.
- The prescaler tick never lasts more than one cycle.

The bench's scenarios cover the rest. It sweeps pulse lengths from 1 to 40 across every line and every prescaler phase. For each pulse it derives the expected long-busy result from the tick arithmetic. It also shows the exact three-edge latency of the edge flag. It lines up writes with a setting edge and with a setting tick to show which event wins. Finally, it checks re-qualification after a clear and restart after a mid-run reset.

// File: rtl/busy_watch_pkg.sv
package busy_watch_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic tick;      // qualification tick from the prescaler
    logic clrLatch;  // clear all edge flags
    logic clrMon;    // clear all long-busy flags
  } bwStrobe_t;

endpackage

// File: rtl/busy_watch_sync.sv
module busy_watch_sync #(
  parameter int LINES  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] asyncIn,
  output logic [LINES-1:0] syncOut
);

  logic [LINES-1:0] stageQ [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= '0;
          else       stageQ[g] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= '0;
          else       stageQ[g] <= stageQ[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/busy_watch_ctrl.sv
module busy_watch_ctrl
  import busy_watch_pkg::*;
#(
  parameter int PRESCALE_W = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrLatch,
  input  logic      wrMon,
  output bwStrobe_t strobe
);

  localparam logic [PRESCALE_W-1:0] LAST = {PRESCALE_W{1'b1}};

  logic [PRESCALE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobe.tick     = (preCnt == LAST);
    strobe.clrLatch = wrLatch;
    strobe.clrMon   = wrMon;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> !strobe.tick);  // R3

endmodule

// File: rtl/busy_watch_dp.sv
module busy_watch_dp
  import busy_watch_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] busySync,
  input  bwStrobe_t        strobe,
  output logic [LINES-1:0] latchQ,
  output logic [LINES-1:0] monQ
);

  logic [LINES-1:0] prevQ;
  logic [LINES-1:0] seenQ;
  logic [LINES-1:0] edgeVec;
  logic [LINES-1:0] monSet;

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : gLine
      assign edgeVec[i] = busySync[i] & ~prevQ[i];
      assign monSet[i]  = busySync[i] & strobe.tick & seenQ[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevQ[i]  <= 1'b0;
          seenQ[i]  <= 1'b0;
          latchQ[i] <= 1'b0;
          monQ[i]   <= 1'b0;
        end else begin
          prevQ[i] <= busySync[i];
          if (!busySync[i])     seenQ[i] <= 1'b0;
          else if (strobe.tick) seenQ[i] <= 1'b1;
          // a same-cycle set wins over the clearing write
          latchQ[i] <= edgeVec[i] | (latchQ[i] & ~strobe.clrLatch);
          monQ[i]   <= monSet[i]  | (monQ[i]   & ~strobe.clrMon);
        end
      end
    end
  endgenerate

  AST_LATCH_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((latchQ & ~$past(latchQ)) & ~$past(busySync)) == '0);  // R2

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.clrLatch) |-> (($past(latchQ) & ~latchQ) == '0));  // R2

  AST_MON_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.tick) |-> ((monQ & ~$past(monQ)) == '0));  // R3

  AST_MON_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((monQ & ~$past(monQ)) & ~($past(busySync) & $past(busySync, 2))) == '0);  // R3

  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clrLatch) |-> ((latchQ & ~$past(busySync)) == '0));  // R4

  AST_MON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.clrMon) && !$past(strobe.tick)) |-> (monQ == '0));  // R4

endmodule

// File: rtl/busy_watch_regs.sv
module busy_watch_regs
  import busy_watch_pkg::*;
#(
  parameter int LINES      = 16,
  parameter int SYNC_DEPTH = 2,
  parameter int PRESCALE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] busyIn,
  input  logic             wrLatch,
  input  logic             wrMon,
  output logic [LINES-1:0] liveRd,
  output logic [LINES-1:0] latchRd,
  output logic [LINES-1:0] monRd
);

  bwStrobe_t        strobe;
  logic [LINES-1:0] busySync;

  assign liveRd = busyIn;

  busy_watch_sync #(.LINES(LINES), .STAGES(SYNC_DEPTH)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (busyIn),
    .syncOut (busySync)
  );

  busy_watch_ctrl #(.PRESCALE_W(PRESCALE_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrLatch (wrLatch),
    .wrMon   (wrMon),
    .strobe  (strobe)
  );

  busy_watch_dp #(.LINES(LINES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .busySync (busySync),
    .strobe   (strobe),
    .latchQ   (latchRd),
    .monQ     (monRd)
  );

  AST_LIVE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    liveRd == busyIn);  // R1

endmodule

// File: tb/busy_watch_regs_tb.sv
module busy_watch_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 16;
  localparam int TICK_EVERY = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LINES-1:0] busyIn = '0;
  logic             wrLatch = 1'b0;
  logic             wrMon = 1'b0;
  logic [LINES-1:0] liveRd, latchRd, monRd;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  bit done = 1'b0;

  busy_watch_regs dut_i (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .wrLatch(wrLatch), .wrMon(wrMon),
    .liveRd(liveRd), .latchRd(latchRd), .monRd(monRd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Edge index since reset release: edge 1 is the first edge with rstN high.
  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  task automatic chk(input string tag, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clearAll();
    wrLatch = 1'b1; wrMon = 1'b1;
    @(negedge clk);
    wrLatch = 1'b0; wrMon = 1'b0;
  endtask

  // Expected long-busy result: at least two ticks among edges s+2 .. s+L+1.
  function automatic bit monExpect(input int s, input int len);
    int n = 0;
    for (int k = s + 2; k <= s + len + 1; k++)
      if (k % TICK_EVERY == 0) n++;
    return n >= 2;
  endfunction

  task automatic pulseCase(input int line, input int len);
    int s;
    logic [LINES-1:0] one;
    one = '0; one[line] = 1'b1;
    negs(4);
    clearAll();
    chk("R4 clear before pulse latch", latchRd, '0);
    chk("R4 clear before pulse mon", monRd, '0);
    s = edgeCnt + 1;
    busyIn = one;
    #1 chk("R1 live follows input", liveRd, one);
    @(negedge clk);
    negs(len - 1);
    busyIn = '0;
    #1 chk("R1 live follows release", liveRd, '0);
    negs(3);
    chk("R2 R8 edge flag on single line", latchRd, one);
    chk("R3 R8 long-busy qualification", monRd, monExpect(s, len) ? one : '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state
    busyIn = 16'hA5C3;
    negs(3);
    #1 chk("R1 live during reset", liveRd, 16'hA5C3);
    chk("R6 latch zero in reset", latchRd, '0);
    chk("R6 mon zero in reset", monRd, '0);
    busyIn = '0;
    negs(2);
    rstN = 1'b1;
    negs(4);

    // exact edge-flag latency
    busyIn = 16'h0008;
    negs(2);
    chk("R2 latch not yet after two edges", latchRd, '0);
    @(negedge clk);
    chk("R2 latch after third edge", latchRd, 16'h0008);
    busyIn = '0;
    negs(10);
    chk("R2 latch held after release", latchRd, 16'h0008);

    // sweep of pulse lengths, lines and prescaler phases
    for (int len = 1; len <= 40; len++) pulseCase(len % LINES, len);
    for (int ln = 0; ln < LINES; ln++) pulseCase(ln, 17 + ln);

    // edge coinciding with latch clear: bit 2 survives, bit 9 cleared
    negs(4);
    clearAll();
    busyIn = 16'h0200;
    negs(6);
    busyIn = 16'h0204;
    negs(2);
    wrLatch = 1'b1;
    @(negedge clk);
    wrLatch = 1'b0;
    chk("R5 edge wins over latch clear", latchRd, 16'h0004);

    // long-high line: clear versus tick, and re-qualification
    busyIn = 16'h0020;
    negs(40);
    chk("R3 long high sets mon", monRd, 16'h0020);
    while (edgeCnt % TICK_EVERY != TICK_EVERY - 1) @(negedge clk);
    wrMon = 1'b1;
    @(negedge clk);
    wrMon = 1'b0;
    chk("R5 tick wins over mon clear", monRd, 16'h0020);
    while (edgeCnt % TICK_EVERY != 3) @(negedge clk);
    wrMon = 1'b1;
    @(negedge clk);
    wrMon = 1'b0;
    chk("R4 mon cleared off tick", monRd, '0);
    while (edgeCnt % TICK_EVERY != TICK_EVERY - 1) @(negedge clk);
    chk("R7 mon stays clear before tick", monRd, '0);
    @(negedge clk);
    chk("R7 mon re-sets at next tick", monRd, 16'h0020);
    wrLatch = 1'b1;
    @(negedge clk);
    wrLatch = 1'b0;
    chk("R4 latch cleared by write", latchRd, '0);
    negs(8);
    chk("R7 latch stays clear while line high", latchRd, '0);

    // mid-run reset then restart of the prescaler
    rstN = 1'b0;
    #1 chk("R6 latch cleared by reset", latchRd, '0);
    chk("R6 mon cleared by reset", monRd, '0);
    busyIn = '0;
    negs(3);
    rstN = 1'b1;
    negs(2);
    pulseCase(7, 20);
    pulseCase(11, 33);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule